// File: doc/BRIEF.md
# Frame-boundary shadow register commit

This block is the configuration register front end of a display controller that drives two video outputs: output 0 (LCD) and output 1 (TV). Each output owns a bank of software-writable shadow registers and a matching bank of active registers. The pixel pipeline reads only the active bank, and software writes only the shadow bank. A new configuration therefore moves to the pipeline as a whole, and only at a frame boundary.

Each output has a commit-request flag. Software can set it but cannot clear it. When the output's vertical-front-porch-start strobe arrives while the flag is set, every shadow register of that output is copied into its active register on that clock edge. The flag then drops, and a one-cycle commit-done pulse is produced for use as an interrupt. A front-porch start with no request leaves the active bank as it was. A per-output stale flag records a shadow write made while a commit was still pending. The two outputs commit independently, each on its own strobe.

Address map (AW = 2 + output bits + index bits; 5 bits by default). Bits [AW-1:AW-2] select the region: 0 is shadow (read/write), 1 is active (read-only), 2 is control, 3 is unused. The next bit field selects the output and the lowest bits select the register index. The control register sits at offset 0 of region 2. On a write, data bit o set to 1 requests a commit for output o. On a read it returns the request flags in bits [NOUT-1:0] and the stale flags in bits [2*NOUT-1:NOUT], with the other bits zero.

Top module: `shadow_commit_top`

## Requirements
- R1: After reset all shadow and active registers are zero, both request flags and both stale flags are zero, `done` is zero and `rd_data` is zero.
- R2: A write to region 0 updates only the addressed shadow register. Writes to region 1 or region 3 change no register.
- R3: On a clock edge where `vfp_start[o]` is high and request flag o is set, all NREG active registers of output o take the shadow values held before that edge, and the request flag clears.
- R4: On an edge where `vfp_start[o]` is high and request flag o is clear, the active registers of output o do not change.
- R5: Writing a 1 in control bit o sets request flag o. Writing 0 has no effect. The flag is cleared only by a commit.
- R6: `done[o]` is high for exactly the one cycle after each commit edge of output o, and low otherwise.
- R7: A request set for one output, or a strobe for one output, never changes the other output's active registers or flags.
- R8: A shadow write to output o while request flag o is set is accepted and sets stale flag o. A commit clears the stale flag. A shadow write on the commit edge itself lands in shadow after the copy, so active gets the old value, and the stale flag is set.
- R9: A request write on the same edge as a commit of that output leaves request flag o set after that edge, so a second commit is pending.
- R10: `rd_data` shows, one cycle after `rd_addr` is applied, the shadow value (region 0), the active value (region 1), the control word (region 2, offset 0) or zero (anything else).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Registered read data, one cycle latency |
| vfp_start | input | NOUT | Per-output vertical-front-porch-start strobe |
| act_data | output | NOUT*NREG*DW | Active registers; output o, index r at bits [(o*NREG+r)*DW +: DW] |
| done | output | NOUT | Per-output one-cycle commit-done pulse |

## Verification
The bench sweeps every register of both outputs over several rounds of data. It checks that a strobe with no request leaves the active bank frozen; a design that copied on every strobe would show the new shadow data early. Writing 0 to the control register while a request is pending must not cancel the request, and a design that let software clear it would lose the commit. The bench also drives a shadow write and a request write on the commit edge itself. A design with the wrong order on that edge would copy the new value, or would drop the re-armed request. Checks that one output's request and strobe leave the other output alone catch crossed enables.

// File: rtl/shcommit_pkg.sv
package shcommit_pkg;
  typedef enum logic [1:0] {
    RGN_SHADOW = 2'd0,
    RGN_ACTIVE = 2'd1,
    RGN_CTRL   = 2'd2,
    RGN_NONE   = 2'd3
  } region_e;
endpackage

// File: rtl/commit_bank.sv
module commit_bank #(
  parameter int DW   = 32,
  parameter int NREG = 4,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shd_we,
  input  logic [IW-1:0]      shd_idx,
  input  logic [DW-1:0]      wdata,
  input  logic               go_set,
  input  logic               vfp,
  output logic [NREG*DW-1:0] shd_q,
  output logic [NREG*DW-1:0] act_q,
  output logic               go_q,
  output logic               pend_q,
  output logic               done_q
);
  logic commit;
  assign commit = vfp & go_q;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        shd_q[r*DW +: DW] <= '0;
      else if (shd_we && shd_idx == IW'(r))
        shd_q[r*DW +: DW] <= wdata;
    end

    always_ff @(posedge clk) begin
      if (rst)
        act_q[r*DW +: DW] <= '0;
      else if (commit)
        act_q[r*DW +: DW] <= shd_q[r*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      go_q   <= 1'b0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      go_q   <= (go_q & ~commit) | go_set;
      pend_q <= (pend_q & ~commit) | (shd_we & go_q);
      done_q <= commit;
    end
  end

  assert_copy_R3: assert property (@(posedge clk) disable iff (rst)
    (vfp && go_q) |=> (act_q == $past(shd_q)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !(vfp && go_q) |=> $stable(act_q));

  assert_hw_clear_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(go_q) |-> $past(vfp));

  assert_go_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (vfp && go_q && !go_set) |=> !go_q);

  assert_done_R6: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(vfp && go_q));

  assert_stale_R8: assert property (@(posedge clk) disable iff (rst)
    (shd_we && go_q) |=> pend_q);

  assert_rearm_R9: assert property (@(posedge clk) disable iff (rst)
    go_set |=> go_q);
endmodule

// File: rtl/shadow_commit_top.sv
module shadow_commit_top
  import shcommit_pkg::*;
#(
  parameter int NOUT = 2,
  parameter int NREG = 4,
  parameter int DW   = 32,
  localparam int OW  = (NOUT > 1) ? $clog2(NOUT) : 1,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int AW  = 2 + OW + IW
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic [AW-1:0]           rd_addr,
  output logic [DW-1:0]           rd_data,
  input  logic [NOUT-1:0]         vfp_start,
  output logic [NOUT*NREG*DW-1:0] act_data,
  output logic [NOUT-1:0]         done
);
  region_e       wr_rgn, rd_rgn;
  logic [OW-1:0] wr_out, rd_out;
  logic [IW-1:0] wr_idx, rd_idx;
  logic          wr_ctl0, rd_ctl0;

  assign wr_rgn  = region_e'(wr_addr[AW-1 -: 2]);
  assign wr_out  = wr_addr[IW +: OW];
  assign wr_idx  = wr_addr[IW-1:0];
  assign wr_ctl0 = (wr_addr[OW+IW-1:0] == '0);
  assign rd_rgn  = region_e'(rd_addr[AW-1 -: 2]);
  assign rd_out  = rd_addr[IW +: OW];
  assign rd_idx  = rd_addr[IW-1:0];
  assign rd_ctl0 = (rd_addr[OW+IW-1:0] == '0);

  logic [NREG*DW-1:0] shd_v [NOUT];
  logic [NREG*DW-1:0] act_v [NOUT];
  logic [NOUT-1:0]    go_v, pend_v;

  for (genvar o = 0; o < NOUT; o++) begin : g_out
    logic shd_we, go_set;
    assign shd_we = wr_en && (wr_rgn == RGN_SHADOW) && (wr_out == OW'(o));
    assign go_set = wr_en && (wr_rgn == RGN_CTRL) && wr_ctl0 && wr_data[o];

    commit_bank #(.DW(DW), .NREG(NREG)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .shd_we  (shd_we),
      .shd_idx (wr_idx),
      .wdata   (wr_data),
      .go_set  (go_set),
      .vfp     (vfp_start[o]),
      .shd_q   (shd_v[o]),
      .act_q   (act_v[o]),
      .go_q    (go_v[o]),
      .pend_q  (pend_v[o]),
      .done_q  (done[o])
    );

    assign act_data[o*NREG*DW +: NREG*DW] = act_v[o];
  end

  logic [DW-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    case (rd_rgn)
      RGN_SHADOW: begin
        for (int o = 0; o < NOUT; o++)
          if (rd_out == OW'(o)) rd_next = shd_v[o][rd_idx*DW +: DW];
      end
      RGN_ACTIVE: begin
        for (int o = 0; o < NOUT; o++)
          if (rd_out == OW'(o)) rd_next = act_v[o][rd_idx*DW +: DW];
      end
      RGN_CTRL: begin
        if (rd_ctl0) begin
          rd_next[NOUT-1:0]      = go_v;
          rd_next[2*NOUT-1:NOUT] = pend_v;
        end
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  assert_rd_reset_R1: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && done == '0));
endmodule

// File: tb/sim_shadow_commit_top.sv
`timescale 1ns/1ps
module sim_shadow_commit_top;
  localparam int NOUT = 2, NREG = 4, DW = 32, AW = 5;

  logic clk = 0, rst = 1, wr_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NOUT-1:0] vfp_start = '0;
  logic [DW-1:0] rd_data;
  logic [NOUT*NREG*DW-1:0] act_data;
  logic [NOUT-1:0] done;

  shadow_commit_top #(.NOUT(NOUT), .NREG(NREG), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .vfp_start(vfp_start),
    .act_data(act_data), .done(done));

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  logic [DW-1:0] shd_m [NOUT][NREG];
  logic [DW-1:0] act_m [NOUT][NREG];
  logic go_m [NOUT];
  logic pend_m [NOUT];
  logic [NOUT-1:0] done_m;

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [AW-1:0] adr(input int rgn, input int o, input int r);
    return {rgn[1:0], o[0], r[1:0]};
  endfunction

  function automatic logic [DW-1:0] pat(input int o, input int r, input int k);
    return (32'h1357_0000 * (k + 1)) ^ (32'(o) << 12) ^ (32'(r) << 4) ^ 32'(k * 7 + 1);
  endfunction

  task automatic chk_act(input string req);
    for (int o = 0; o < NOUT; o++)
      for (int r = 0; r < NREG; r++)
        chk(req, act_data[(o*NREG+r)*DW +: DW], act_m[o][r]);
  endtask

  // one clock with optional write and strobes; model updated from requirements
  task automatic cyc(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic [NOUT-1:0] v);
    logic [NOUT-1:0] com;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; vfp_start = v;
    @(posedge clk);
    #1;
    wr_en = 0; vfp_start = '0;
    for (int o = 0; o < NOUT; o++) begin
      com[o] = v[o] & go_m[o];
      if (com[o]) begin
        for (int r = 0; r < NREG; r++) act_m[o][r] = shd_m[o][r];
        go_m[o] = 0; pend_m[o] = 0;
      end
    end
    if (we && a[4:3] == 2'd0) begin
      if (go_m[a[2]] || com[a[2]]) pend_m[a[2]] = 1;
      shd_m[a[2]][a[1:0]] = d;
    end
    if (we && a[4:3] == 2'd2 && a[2:0] == 3'd0)
      for (int o = 0; o < NOUT; o++) if (d[o]) go_m[o] = 1;
    done_m = com;
    chk("R6 done", 32'(done), 32'(done_m));
    chk_act("R3/R4 active");
  endtask

  function automatic logic [DW-1:0] rd_exp(input logic [AW-1:0] a);
    case (a[4:3])
      2'd0: return shd_m[a[2]][a[1:0]];
      2'd1: return act_m[a[2]][a[1:0]];
      2'd2: return (a[2:0] == 0) ? 32'({pend_m[1], pend_m[0], go_m[1], go_m[0]}) : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  task automatic rd(input string req, input logic [AW-1:0] a);
    @(negedge clk);
    rd_addr = a;
    @(posedge clk);
    #1;
    chk(req, rd_data, rd_exp(a));
  endtask

  task automatic rd_all(input string req);
    for (int g = 0; g < 2; g++)
      for (int o = 0; o < NOUT; o++)
        for (int r = 0; r < NREG; r++) rd(req, adr(g, o, r));
    rd(req, adr(2, 0, 0));
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int o = 0; o < NOUT; o++) begin
      go_m[o] = 0; pend_m[o] = 0;
      for (int r = 0; r < NREG; r++) begin shd_m[o][r] = 0; act_m[o][r] = 0; end
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    // R1 reset state
    chk("R1 done", 32'(done), 0);
    chk("R1 rd_data", rd_data, 0);
    chk_act("R1 active");
    rd_all("R1 reads");

    // R2 shadow sweep, active untouched
    for (int o = 0; o < NOUT; o++)
      for (int r = 0; r < NREG; r++) cyc(1, adr(0, o, r), pat(o, r, 0), 0);
    rd_all("R2/R10 readback");
    // R2 writes to active and unused regions ignored
    cyc(1, adr(1, 0, 1), 32'hDEAD_BEEF, 0);
    cyc(1, adr(3, 1, 2), 32'hCAFE_F00D, 0);
    rd_all("R2 ignored writes");
    rd("R10 unused region", adr(3, 0, 0));
    rd("R10 ctrl nonzero offset", adr(2, 1, 3));

    // R4 strobes without request
    cyc(0, 0, 0, 2'b11);
    chk_act("R4 no request");
    // R5 writing 0 to control does nothing
    cyc(1, adr(2, 0, 0), 32'h0, 0);
    rd("R5 write zero", adr(2, 0, 0));

    // R5/R7 request LCD only, strobe TV only
    cyc(1, adr(2, 0, 0), 32'h1, 0);
    rd("R5 set lcd", adr(2, 0, 0));
    cyc(0, 0, 0, 2'b10);
    chk_act("R7 tv strobe ignores lcd request");
    rd("R7 ctrl after tv strobe", adr(2, 0, 0));
    cyc(0, 0, 0, 2'b01);
    chk("R3 lcd committed", act_data[0 +: DW], pat(0, 0, 0));
    chk("R7 tv unchanged", act_data[NREG*DW +: DW], 0);
    cyc(0, 0, 0, 0);
    chk("R6 pulse ends", 32'(done), 0);
    rd("R3 go cleared", adr(2, 0, 0));

    // R5 cannot cancel; R8 stale flag
    cyc(1, adr(2, 0, 0), 32'h2, 0);
    cyc(1, adr(2, 0, 0), 32'h0, 0);
    rd("R5 zero cannot clear", adr(2, 0, 0));
    chk("R5 expect tv go", rd_data, 32'h2);
    cyc(1, adr(0, 1, 0), 32'h0BAD_0001, 0);
    rd("R8 stale set", adr(2, 0, 0));
    chk("R8 ctrl value", rd_data, 32'hA);
    cyc(1, adr(0, 1, 1), 32'h0BAD_0002, 2'b10);
    chk("R8 old value copied", act_data[(NREG+1)*DW +: DW], pat(1, 1, 0));
    rd("R8 new value in shadow", adr(0, 1, 1));
    rd("R8 stale after same-edge write", adr(2, 0, 0));
    chk("R8 ctrl expect stale only", rd_data, 32'h8);
    cyc(1, adr(2, 0, 0), 32'h2, 0);
    cyc(0, 0, 0, 2'b10);
    rd("R8 stale cleared", adr(2, 0, 0));

    // R9 request on commit edge
    cyc(1, adr(2, 0, 0), 32'h1, 0);
    cyc(1, adr(0, 0, 3), 32'h7777_0003, 0);
    cyc(1, adr(2, 0, 0), 32'h1, 2'b01);
    rd("R9 rearmed", adr(2, 0, 0));
    cyc(0, 0, 0, 2'b01);
    chk("R9 second commit", act_data[3*DW +: DW], 32'h7777_0003);

    // full rounds on both outputs
    for (int k = 1; k < 5; k++) begin
      for (int o = 0; o < NOUT; o++)
        for (int r = 0; r < NREG; r++) cyc(1, adr(0, o, r), pat(o, r, k), 0);
      cyc(0, 0, 0, 2'b11);
      cyc(1, adr(2, 0, 0), 32'h3, 0);
      cyc(0, 0, 0, 2'b11);
      rd_all("R3/R10 round");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule